// File: doc/BRIEF.md
# LED Sink Channel Feedback Mask Controller

This block decides which of six LED current-sink channels exist and which of them steer the boost converter. It holds two per-channel vectors. The enabled vector marks channels that have a string attached. The regulation vector marks channels whose pin voltage feeds the boost loop. The AND of the two vectors drives the feedback-select output, which goes to the minimum-voltage selector.

At the end of the detection phase, the startup sequencer pulses a strobe. Any channel whose pin sits under 100 mV is taken as grounded and unused. It is left out of both vectors.

When an over-voltage event occurs, each channel that is still in regulation but is below its regulation point is taken out of feedback. The channel stays enabled, so its sink keeps conducting if the string comes back. The same over-voltage event brings back any removed channel whose open condition has gone. A re-enable pulse brings back every removed channel at once.

Whenever the block has been armed by a detection strobe and the feedback set is empty, it raises a flag so that the supervisor can shut the converter down.

Top module: `ledFbMaskTop`

## Requirements
- R1: After a synchronous active-low reset, enMask, regMask and fbSelect are all zero and allOut is low, and they stay that way until a detection strobe.
- R2: A detection strobe loads enMask bit i with the inverse of pinLow bit i, where bit i is channel i. It also loads regMask with the same value.
- R3: An over-voltage event clears regMask bit i when channel i is enabled, in regulation, and flagged belowReg. It leaves enMask unchanged.
- R4: fbSelect is always the bitwise AND of enMask and regMask. regMask never holds a bit that enMask lacks.
- R5: A re-enable pulse sets regMask equal to enMask and leaves enMask unchanged.
- R6: An over-voltage event sets regMask bit i again when channel i is enabled, out of regulation, and flagged openCleared.
- R7: Once the block is armed by a detection strobe, allOut is high exactly while fbSelect is zero.
- R8: Priority among strobes in the same cycle is detection first, then re-enable, then over-voltage.
- R9: Without a strobe, the belowReg, openCleared and pinLow inputs have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| detectStrobe | input | 1 | End of channel detection phase |
| pinLow | input | 6 | Channel pin below 100 mV |
| belowReg | input | 6 | Channel pin below regulation |
| ovpEvent | input | 1 | Over-voltage event pulse |
| reEnable | input | 1 | Device re-enable pulse |
| openCleared | input | 6 | Channel open condition has cleared |
| enMask | output | 6 | Enabled channels |
| regMask | output | 6 | Channels in regulation |
| fbSelect | output | 6 | Channels used for boost feedback |
| allOut | output | 1 | Feedback set is empty after arming |

## Verification
The bench runs detection over all 64 pin patterns. After each detection it sends over-voltage events built from several belowReg and openCleared patterns. These include the case where every enabled channel is removed, which a design that forgot the flag would leave silent with an empty feedback set. It also covers the case where an enabled channel is both below regulation and cleared; a design that disabled open strings instead of only unregulating them would show that channel missing from enMask. Finally, the bench drives strobes together and drives noisy inputs with no strobe, which catch a wrong priority order and state that changes when no strobe is present.

// File: rtl/ledFbMaskPkg.sv
package ledFbMaskPkg;
  localparam int NUM_CH = 6;

  typedef logic [NUM_CH-1:0] chVec_t;

  typedef struct packed {
    logic doDetect;
    logic doRestoreAll;
    logic doOvp;
  } maskStrobes_t;
endpackage

// File: rtl/ledFbMaskCtrl.sv
module ledFbMaskCtrl
  import ledFbMaskPkg::*;
(
  input  logic         detectStrobe,
  input  logic         reEnable,
  input  logic         ovpEvent,
  output maskStrobes_t strobes
);
  // Fixed priority: detection over re-enable over over-voltage
  always_comb begin
    strobes              = '0;
    strobes.doDetect     = detectStrobe;
    strobes.doRestoreAll = reEnable & ~detectStrobe;
    strobes.doOvp        = ovpEvent & ~reEnable & ~detectStrobe;
  end
endmodule

// File: rtl/ledFbMaskPath.sv
module ledFbMaskPath
  import ledFbMaskPkg::*;
#(
  parameter int CH = NUM_CH
) (
  input  logic          clk,
  input  logic          rstN,
  input  maskStrobes_t  strobes,
  input  logic [CH-1:0] pinLow,
  input  logic [CH-1:0] belowReg,
  input  logic [CH-1:0] openCleared,
  output logic [CH-1:0] enMask,
  output logic [CH-1:0] regMask,
  output logic [CH-1:0] fbSelect,
  output logic          allOut
);
  logic [CH-1:0] enQ, regQ, enNext, regNext;
  logic          armedQ;

  for (genvar i = 0; i < CH; i++) begin : g_ch
    logic dropBit, backBit;
    assign dropBit = enQ[i] & regQ[i] & belowReg[i];
    assign backBit = enQ[i] & ~regQ[i] & openCleared[i];
    always_comb begin
      enNext[i]  = enQ[i];
      regNext[i] = regQ[i];
      if (strobes.doDetect) begin
        enNext[i]  = ~pinLow[i];
        regNext[i] = ~pinLow[i];
      end else if (strobes.doRestoreAll) begin
        regNext[i] = enQ[i];
      end else if (strobes.doOvp) begin
        regNext[i] = (regQ[i] & ~dropBit) | backBit;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ    <= '0;
      regQ   <= '0;
      armedQ <= 1'b0;
    end else begin
      enQ  <= enNext;
      regQ <= regNext;
      if (strobes.doDetect) armedQ <= 1'b1;
    end
  end

  assign enMask   = enQ;
  assign regMask  = regQ;
  assign fbSelect = enQ & regQ;
  assign allOut   = armedQ & ~|(enQ & regQ);
endmodule

// File: rtl/ledFbMaskTop.sv
module ledFbMaskTop
  import ledFbMaskPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              detectStrobe,
  input  logic [NUM_CH-1:0] pinLow,
  input  logic [NUM_CH-1:0] belowReg,
  input  logic              ovpEvent,
  input  logic              reEnable,
  input  logic [NUM_CH-1:0] openCleared,
  output logic [NUM_CH-1:0] enMask,
  output logic [NUM_CH-1:0] regMask,
  output logic [NUM_CH-1:0] fbSelect,
  output logic              allOut
);
  maskStrobes_t strobes;

  ledFbMaskCtrl ctrl_i (
    .detectStrobe(detectStrobe),
    .reEnable    (reEnable),
    .ovpEvent    (ovpEvent),
    .strobes     (strobes)
  );

  ledFbMaskPath #(.CH(NUM_CH)) path_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .pinLow     (pinLow),
    .belowReg   (belowReg),
    .openCleared(openCleared),
    .enMask     (enMask),
    .regMask    (regMask),
    .fbSelect   (fbSelect),
    .allOut     (allOut)
  );
endmodule

// File: rtl/ledFbMaskChecker.sv
module ledFbMaskChecker
  import ledFbMaskPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              detectStrobe,
  input logic [NUM_CH-1:0] belowReg,
  input logic              ovpEvent,
  input logic              reEnable,
  input logic [NUM_CH-1:0] openCleared,
  input logic [NUM_CH-1:0] enMask,
  input logic [NUM_CH-1:0] regMask,
  input logic [NUM_CH-1:0] fbSelect,
  input logic              allOut
);
  logic seenDetect;
  always_ff @(posedge clk) begin
    if (!rstN) seenDetect <= 1'b0;
    else if (detectStrobe) seenDetect <= 1'b1;
  end

  AST_REG_WITHIN_EN: assert property (@(posedge clk) disable iff (!rstN)
    (regMask & ~enMask) == '0);  // R4
  AST_EMPTY_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    (seenDetect && fbSelect == '0) |-> allOut);  // R7
  AST_UNARMED_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    !seenDetect |-> (enMask == '0 && !allOut));  // R1
  AST_EN_KEPT_ON_OVP: assert property (@(posedge clk) disable iff (!rstN)
    (ovpEvent && !detectStrobe) |=> $stable(enMask));  // R3
  AST_OVP_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (ovpEvent && !detectStrobe && !reEnable)
      |=> (regMask & $past(fbSelect & belowReg & ~openCleared)) == '0);  // R3
  AST_REENABLE_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (reEnable && !detectStrobe) |=> regMask == enMask);  // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!detectStrobe && !reEnable && !ovpEvent) |=> ($stable(regMask) && $stable(enMask)));  // R9
endmodule

bind ledFbMaskTop ledFbMaskChecker chk_i (
  .clk(clk), .rstN(rstN), .detectStrobe(detectStrobe), .belowReg(belowReg),
  .ovpEvent(ovpEvent), .reEnable(reEnable), .openCleared(openCleared),
  .enMask(enMask), .regMask(regMask), .fbSelect(fbSelect), .allOut(allOut)
);

// File: tb/ledFbMaskTop_tb.sv
module ledFbMaskTop_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CH = 6;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic detectStrobe = 1'b0, ovpEvent = 1'b0, reEnable = 1'b0;
  logic [CH-1:0] pinLow = '0, belowReg = '0, openCleared = '0;
  logic [CH-1:0] enMask, regMask, fbSelect;
  logic allOut;

  int nChecks = 0;
  int nFails = 0;
  logic [CH-1:0] mEn = '0, mReg = '0;
  logic mArmed = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ledFbMaskTop dut_i (
    .clk(clk), .rstN(rstN), .detectStrobe(detectStrobe), .pinLow(pinLow),
    .belowReg(belowReg), .ovpEvent(ovpEvent), .reEnable(reEnable),
    .openCleared(openCleared), .enMask(enMask), .regMask(regMask),
    .fbSelect(fbSelect), .allOut(allOut)
  );

  task automatic check(string req);
    logic [CH-1:0] eFb;
    logic eFlag;
    eFb = mEn & mReg;
    eFlag = mArmed && (eFb == '0);
    nChecks++;
    if (enMask !== mEn || regMask !== mReg || fbSelect !== eFb || allOut !== eFlag) begin
      nFails++;
      $display("FAIL %s: en=%b reg=%b fb=%b flag=%b expected en=%b reg=%b fb=%b flag=%b",
               req, enMask, regMask, fbSelect, allOut, mEn, mReg, eFb, eFlag);
    end
  endtask

  // Drive at negedge, let one posedge capture, check at next negedge
  task automatic apply(input logic det, input logic [CH-1:0] pl, input logic ov,
                       input logic [CH-1:0] br, input logic re,
                       input logic [CH-1:0] oc, input string req);
    detectStrobe = det; pinLow = pl; ovpEvent = ov; belowReg = br;
    reEnable = re; openCleared = oc;
    if (det) begin
      mEn = ~pl; mReg = ~pl; mArmed = 1'b1;
    end else if (re) begin
      mReg = mEn;
    end else if (ov) begin
      mReg = (mReg & ~(mEn & mReg & br)) | (mEn & ~mReg & oc);
    end
    @(negedge clk);
    detectStrobe = 1'b0; ovpEvent = 1'b0; reEnable = 1'b0;
    check(req);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1 reset");
    // R9 noise without strobes before arming
    apply(1'b0, 6'h2A, 1'b0, 6'h3F, 1'b0, 6'h3F, "R9 idle unarmed");
    apply(1'b0, '0, 1'b1, 6'h3F, 1'b0, 6'h3F, "R1 ovp before detect");

    for (int d = 0; d < 64; d++) begin
      apply(1'b1, d[CH-1:0], 1'b0, '0, 1'b0, '0, "R2 detect");
      for (int b = 0; b < 64; b += 9) begin
        apply(1'b0, '0, 1'b1, b[CH-1:0], 1'b0, '0, "R3 ovp remove");
        apply(1'b0, 6'h3F, 1'b0, 6'h3F, 1'b0, 6'h3F, "R9 idle noise");
        apply(1'b0, '0, 1'b1, b[CH-1:0], 1'b0, b[CH-1:0] ^ 6'h15, "R6 ovp restore cleared");
        apply(1'b0, '0, 1'b1, 6'h3F, 1'b0, '0, "R7 ovp remove all");
        apply(1'b0, '0, 1'b1, '0, 1'b1, '0, "R8 re-enable over ovp R5");
      end
    end

    // R8 detection wins over everything in the same cycle
    apply(1'b1, 6'h00, 1'b0, '0, 1'b0, '0, "R2 detect all");
    apply(1'b1, 6'h21, 1'b1, 6'h3F, 1'b1, '0, "R8 detect priority");
    // R4 belowReg and cleared both set on a removed channel
    apply(1'b0, '0, 1'b1, 6'h02, 1'b0, '0, "R3 drop ch1");
    apply(1'b0, '0, 1'b1, 6'h02, 1'b0, 6'h02, "R6 cleared and below");
    apply(1'b0, '0, 1'b0, '0, 1'b1, '0, "R5 re-enable");
    apply(1'b1, 6'h3F, 1'b0, '0, 1'b0, '0, "R7 detect none used");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule